// File: doc/BRIEF.md
# Rotating Framebuffer Scan Address Generator

This block produces the byte addresses used to fetch pixel data for an LCD panel. A timing generator supplies a frame-start pulse, a line tick and a fetch tick. The block turns these into one fetch address per fetch tick, which a bus master consumes. The programmable inputs are:

- the frame buffer base,
- the line stride in bytes,
- the panel width in pixels and its height in lines,
- a rotation request,
- a dual-scan flag.

In normal raster order the scan walks each line left to right, one fetch word at a time. At each line tick it moves down by one stride. In rotated order the panel is driven through a 90-degree turn. The scan starts at the bottom row of the stored image and climbs one stride per fetch. At each line tick it moves one byte column to the right. Rotation needs a power-of-two stride, so the block rounds the programmed stride up. Rotation is only honoured for narrow panels. Dual-scan panels get a second, lower-half address stream that runs in lockstep with the upper one. Every emitted address has its two region bits forced high. This places the frame buffer in one fixed 64 MiB window.

The configuration is sampled only on the frame-start pulse. Software may rewrite it at any time without tearing the frame in progress.

Top module: `fb_scan_addr`

## Requirements
- R1: After reset `upper_valid`, `lower_valid` and `rotated` are 0. Fetch and line ticks have no effect until the first `frame_start`.
- R2: In normal order the first fetch of a frame is at `base_addr`. Each further fetch in a line is 4 bytes higher. A line tick moves the line start down by `line_stride` bytes, and the next fetch is issued from that new line start.
- R3: Rotation takes effect, and `rotated` reads 1, only when `rotate_req` is 1 and `h_pixels` is 320 or less. Otherwise the frame runs in normal order with `rotated` at 0.
- R4: In rotated order the first fetch is at `base_addr + (h_pixels-1)*S`, where S is the effective stride. Each further fetch is S bytes lower. A line tick moves the line start up by 1 byte.
- R5: In rotated order S is `line_stride` rounded up to the next power of two. A power-of-two stride is used unchanged. In normal order S equals `line_stride`.
- R6: Bits 27 and 26 of `upper_addr` and `lower_addr` are 1 on every valid fetch. Bits 25:0 carry the computed address modulo 2^26.
- R7: With `dual_scan` latched at 1, every fetch also produces `lower_valid` and `lower_addr`. The lower stream starts at upper start + S*(v_lines/2) in normal order, or upper start + S*(h_pixels/2) in rotated order, with integer halving. It steps exactly as the upper stream does. With `dual_scan` latched at 0, `lower_valid` stays 0.
- R8: All configuration inputs are captured at `frame_start`. Changes made during a frame have no effect on its addresses until the next `frame_start`.
- R9: When ticks coincide, `frame_start` wins over `line_tick`, which wins over `fetch_tick`. A fetch tick that loses produces no fetch.
- R10: A fetch tick sampled at a clock edge raises `upper_valid` with its address for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: latch configuration and restart the scan |
| line_tick | input | 1 | Pulse: advance to the next display line |
| fetch_tick | input | 1 | Pulse: issue one fetch from the current position |
| base_addr | input | 28 | Frame buffer start byte address |
| line_stride | input | 16 | Bytes between consecutive display lines |
| h_pixels | input | 11 | Panel width in pixels (1..1024) |
| v_lines | input | 11 | Panel height in lines (1..1024) |
| rotate_req | input | 1 | Request 90-degree rotated scan |
| dual_scan | input | 1 | Panel is dual-scan; enable the lower stream |
| upper_addr | output | 28 | Upper-half fetch byte address |
| upper_valid | output | 1 | Upper fetch strobe |
| lower_addr | output | 28 | Lower-half fetch byte address |
| lower_valid | output | 1 | Lower fetch strobe |
| rotated | output | 1 | The current frame runs in rotated order |

## Verification
The bench targets the rotation boundary at a width of exactly 320 and 321 pixels. A design with an off-by-one compare there would rotate a wide panel, or refuse a legal one, and every address would then be wrong. It drives non-power-of-two and exact power-of-two strides in rotated order. A faulty rounder would either leave the stride unrounded or double a stride that is already a power of two, which shifts the start row and each step.

Dual-scan frames with odd line counts exercise the lower-half offset. A wrong halving or a wrong choice of dimension would appear as a lower stream at a constant wrong distance. Mid-frame register rewrites and coincident ticks probe the capture and priority rules. A design lacking either would jump to a new base in the middle of a frame, or emit a fetch from a stale line start.

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
  parameter int AW         = 28,
  parameter int SW         = 16,
  parameter int RW         = 11,
  parameter int WORD_BYTES = 4,
  parameter int FIX_LSB    = 26,
  parameter int FIX_BITS   = 2,
  parameter int ROT_MAX    = 320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_tick,
  input  logic          fetch_tick,
  input  logic [AW-1:0] base_addr,
  input  logic [SW-1:0] line_stride,
  input  logic [RW-1:0] h_pixels,
  input  logic [RW-1:0] v_lines,
  input  logic          rotate_req,
  input  logic          dual_scan,
  output logic [AW-1:0] upper_addr,
  output logic          upper_valid,
  output logic [AW-1:0] lower_addr,
  output logic          lower_valid,
  output logic          rotated
);

  localparam logic [AW-1:0] FIX_MASK = AW'(((1 << FIX_BITS) - 1) << FIX_LSB);

  logic          rot_ok;
  logic [SW:0]   msb_bit;
  logic [SW:0]   pow2_stride;
  logic [SW:0]   stride_sel;
  logic [RW-1:0] half_span;
  logic [AW-1:0] rot_off, lo_off, start_up;

  logic          dual_q, active_q;
  logic [SW:0]   stride_q;
  logic [AW-1:0] up_line, up_ptr, lo_line, lo_ptr;
  logic [AW-1:0] line_step, fetch_step;

  assign rot_ok = rotate_req && (h_pixels <= RW'(ROT_MAX));

  always_comb begin
    msb_bit = '0;
    for (int i = 0; i < SW; i++)
      if (line_stride[i]) msb_bit = (SW+1)'(1) << i;
    if (({1'b0, line_stride} & ~msb_bit) != '0)
      pow2_stride = msb_bit << 1;
    else
      pow2_stride = msb_bit;
  end

  assign stride_sel = rot_ok ? pow2_stride : {1'b0, line_stride};
  assign rot_off    = AW'(h_pixels - RW'(1)) * AW'(stride_sel);
  assign start_up   = base_addr + (rot_ok ? rot_off : '0);
  assign half_span  = rot_ok ? (h_pixels >> 1) : (v_lines >> 1);
  assign lo_off     = AW'(half_span) * AW'(stride_sel);

  assign line_step  = rotated ? AW'(1) : AW'(stride_q);
  assign fetch_step = rotated ? (AW'(0) - AW'(stride_q)) : AW'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rotated     <= 1'b0;
      dual_q      <= 1'b0;
      active_q    <= 1'b0;
      stride_q    <= '0;
      up_line     <= '0;
      up_ptr      <= '0;
      lo_line     <= '0;
      lo_ptr      <= '0;
      upper_addr  <= '0;
      lower_addr  <= '0;
      upper_valid <= 1'b0;
      lower_valid <= 1'b0;
    end else begin
      upper_valid <= 1'b0;
      lower_valid <= 1'b0;
      if (frame_start) begin
        active_q <= 1'b1;
        rotated  <= rot_ok;
        dual_q   <= dual_scan;
        stride_q <= stride_sel;
        up_line  <= start_up;
        up_ptr   <= start_up;
        lo_line  <= start_up + lo_off;
        lo_ptr   <= start_up + lo_off;
      end else if (active_q && line_tick) begin
        up_line <= up_line + line_step;
        up_ptr  <= up_line + line_step;
        lo_line <= lo_line + line_step;
        lo_ptr  <= lo_line + line_step;
      end else if (active_q && fetch_tick) begin
        upper_valid <= 1'b1;
        upper_addr  <= up_ptr | FIX_MASK;
        up_ptr      <= up_ptr + fetch_step;
        lower_valid <= dual_q;
        lower_addr  <= lo_ptr | FIX_MASK;
        lo_ptr      <= lo_ptr + fetch_step;
      end
    end
  end

endmodule

module fb_scan_addr_chk #(
  parameter int AW         = 28,
  parameter int SW         = 16,
  parameter int WORD_BYTES = 4,
  parameter int FIX_LSB    = 26,
  parameter int FIX_BITS   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          line_tick,
  input logic          upper_valid,
  input logic [AW-1:0] upper_addr,
  input logic          lower_valid,
  input logic [AW-1:0] lower_addr,
  input logic          rotated,
  input logic [SW:0]   stride_q
);
  localparam int LW = FIX_LSB;

  a_r6_upper_region: assert property (@(posedge clk) disable iff (!rst_n)
    upper_valid |-> (&upper_addr[FIX_LSB+FIX_BITS-1:FIX_LSB]));

  a_r6_lower_region: assert property (@(posedge clk) disable iff (!rst_n)
    lower_valid |-> (&lower_addr[FIX_LSB+FIX_BITS-1:FIX_LSB]));

  a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_valid && $past(upper_valid) && !rotated) |->
      (upper_addr[LW-1:0] == ($past(upper_addr[LW-1:0]) + LW'(WORD_BYTES))));

  a_r4_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_valid && $past(upper_valid) && rotated) |->
      (upper_addr[LW-1:0] == ($past(upper_addr[LW-1:0]) - LW'(stride_q))));

  a_r7_lower_paired: assert property (@(posedge clk) disable iff (!rst_n)
    lower_valid |-> upper_valid);

  a_r7_lower_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_valid && $past(lower_valid)) |->
      ((lower_addr[LW-1:0] - upper_addr[LW-1:0]) ==
       ($past(lower_addr[LW-1:0]) - $past(upper_addr[LW-1:0]))));

  a_r9_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> !upper_valid);

  a_r9_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !upper_valid);
endmodule

bind fb_scan_addr fb_scan_addr_chk #(
  .AW(AW), .SW(SW), .WORD_BYTES(WORD_BYTES), .FIX_LSB(FIX_LSB), .FIX_BITS(FIX_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
  .upper_valid(upper_valid), .upper_addr(upper_addr),
  .lower_valid(lower_valid), .lower_addr(lower_addr),
  .rotated(rotated), .stride_q(stride_q)
);

// File: tb/fb_scan_addr_tb.sv
module fb_scan_addr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, line_tick = 1'b0, fetch_tick = 1'b0;
  logic [27:0] base_addr = '0;
  logic [15:0] line_stride = '0;
  logic [10:0] h_pixels = 11'd1, v_lines = 11'd1;
  logic        rotate_req = 1'b0, dual_scan = 1'b0;
  logic [27:0] upper_addr, lower_addr;
  logic        upper_valid, lower_valid, rotated;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [27:0] m_up_line, m_up_ptr, m_lo_line, m_lo_ptr;
  logic        m_rot, m_dual;
  int          m_stride;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_scan_addr dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
    .fetch_tick(fetch_tick), .base_addr(base_addr), .line_stride(line_stride),
    .h_pixels(h_pixels), .v_lines(v_lines), .rotate_req(rotate_req),
    .dual_scan(dual_scan), .upper_addr(upper_addr), .upper_valid(upper_valid),
    .lower_addr(lower_addr), .lower_valid(lower_valid), .rotated(rotated)
  );

  function automatic int ceil_pow2(int s);
    int p = 1;
    while (p < s) p = p * 2;
    return p;
  endfunction

  function automatic logic [27:0] region(logic [27:0] a);
    return {2'b11, a[25:0]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_frame(string req);
    int half;
    m_rot    = rotate_req && (h_pixels <= 11'd320);
    m_dual   = dual_scan;
    m_stride = m_rot ? ceil_pow2(int'(line_stride)) : int'(line_stride);
    m_up_line = base_addr + (m_rot ? 28'((int'(h_pixels) - 1) * m_stride) : 28'd0);
    half = m_rot ? int'(h_pixels) / 2 : int'(v_lines) / 2;
    m_lo_line = m_up_line + 28'(m_stride * half);
    m_up_ptr = m_up_line;
    m_lo_ptr = m_lo_line;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(rotated == m_rot, req, "rotated flag", rotated, m_rot);
  endtask

  task automatic do_line();
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    m_up_line = m_up_line + (m_rot ? 28'd1 : 28'(m_stride));
    m_lo_line = m_lo_line + (m_rot ? 28'd1 : 28'(m_stride));
    m_up_ptr = m_up_line;
    m_lo_ptr = m_lo_line;
  endtask

  task automatic do_fetch(string req);
    logic [27:0] step;
    fetch_tick = 1'b1;
    @(negedge clk);
    fetch_tick = 1'b0;
    check(upper_valid == 1'b1, req, "upper_valid", upper_valid, 1);
    check(upper_addr == region(m_up_ptr), req, "upper_addr", upper_addr, region(m_up_ptr));
    if (m_dual) begin
      check(lower_valid == 1'b1, req, "lower_valid", lower_valid, 1);
      check(lower_addr == region(m_lo_ptr), req, "lower_addr", lower_addr, region(m_lo_ptr));
    end else
      check(lower_valid == 1'b0, "R7", "lower_valid idle", lower_valid, 0);
    step = m_rot ? (28'd0 - 28'(m_stride)) : 28'd4;
    m_up_ptr = m_up_ptr + step;
    m_lo_ptr = m_lo_ptr + step;
  endtask

  task automatic set_cfg(logic [27:0] b, int s, int h, int v, bit r, bit d);
    base_addr = b; line_stride = 16'(s); h_pixels = 11'(h); v_lines = 11'(v);
    rotate_req = r; dual_scan = d;
  endtask

  task automatic frame(string req, int lines, int fetches);
    start_frame(req);
    for (int l = 0; l < lines; l++) begin
      for (int f = 0; f < fetches; f++) do_fetch(req);
      do_line();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and ticks before any frame start
    check(upper_valid == 0 && lower_valid == 0, "R1", "valid after reset", upper_valid, 0);
    check(rotated == 0, "R1", "rotated after reset", rotated, 0);
    fetch_tick = 1'b1; @(negedge clk); fetch_tick = 1'b0;
    check(upper_valid == 0, "R1", "fetch before frame", upper_valid, 0);

    // R2/R6/R10: normal raster
    set_cfg(28'h0123400, 1280, 640, 480, 0, 0);
    frame("R2", 3, 5);
    do_fetch("R10");
    @(negedge clk);
    check(upper_valid == 0, "R10", "single-cycle strobe", upper_valid, 0);

    // R3/R4/R5: rotation at width limit, stride 300 rounds to 512
    set_cfg(28'h0200000, 300, 320, 240, 1, 0);
    frame("R4", 2, 4);
    check(m_stride == 512, "R5", "model stride", m_stride, 512);
    // R3: width 321 falls back to normal
    set_cfg(28'h0200000, 300, 321, 240, 1, 0);
    frame("R3", 2, 3);
    // R5: power of two kept
    set_cfg(28'h0300010, 256, 240, 320, 1, 0);
    frame("R5", 2, 3);

    // R7: dual scan, normal (odd lines) and rotated
    set_cfg(28'h0010000, 640, 320, 241, 0, 1);
    frame("R7", 2, 3);
    set_cfg(28'h0010000, 200, 199, 100, 1, 1);
    frame("R7", 2, 3);

    // R8: configuration rewritten mid-frame
    set_cfg(28'h0400000, 512, 256, 256, 0, 0);
    start_frame("R8");
    do_fetch("R8");
    set_cfg(28'h0FFF000, 77, 100, 10, 1, 1);
    do_fetch("R8");
    do_line();
    do_fetch("R8");

    // R9: coincident ticks
    line_tick = 1'b1; fetch_tick = 1'b1; @(negedge clk);
    line_tick = 1'b0; fetch_tick = 1'b0;
    check(upper_valid == 0, "R9", "line beats fetch", upper_valid, 0);
    m_up_line = m_up_line + 28'(m_stride); m_up_ptr = m_up_line;
    m_lo_line = m_lo_line + 28'(m_stride); m_lo_ptr = m_lo_line;
    do_fetch("R9");
    set_cfg(28'h0500000, 64, 64, 64, 0, 0);
    line_tick = 1'b1; fetch_tick = 1'b1;
    start_frame("R9");
    line_tick = 1'b0; fetch_tick = 1'b0;
    check(upper_valid == 0, "R9", "frame beats others", upper_valid, 0);
    do_fetch("R9");

    // random frames
    for (int k = 0; k < 25; k++) begin
      set_cfg(28'($urandom), int'($urandom_range(1, 4095)), int'($urandom_range(1, 1024)),
              int'($urandom_range(1, 1024)), 1'($urandom), 1'($urandom));
      if (k % 4 == 0) h_pixels = 11'($urandom_range(1, 320));
      frame("R4", int'($urandom_range(1, 4)), int'($urandom_range(1, 6)));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule